// File: doc/BRIEF.md
# PLL Divider Ratio Solver

This block turns a requested PLL output frequency and the frequency of the reference clock into the pair of integer divider settings a fractional-ratio PLL needs: a feedback multiplier N and a reference divider M, so that output = reference × N / M. Both frequencies arrive as unsigned integers in Hz and are captured on a single-cycle start pulse. The answer comes back several tens of cycles later, together with a bypass flag and a one-cycle done strobe.

When the requested frequency does not exceed the reference, the solver answers at once with N = M = 0 and the bypass flag set, meaning the PLL is bypassed and the output runs at the reference frequency. Otherwise the request is clamped into the legal VCO window. The ratio is reduced by the greatest common divisor of clamped target and reference, found by a binary GCD engine. Two serial restoring dividers then divide both terms by that divisor. Finally both terms are halved together until N fits in 12 bits and M in 9 bits, and any term that has reached zero is raised to one.

Top module: `pll_ratio_solver`

## Requirements
- R1: A start with target_hz <= ref_hz gives n_div = 0, m_div = 0 and bypass = 1, with done high on the first clock edge after the start, and busy never rises.
- R2: A start with target_hz > ref_hz first clamps the target into the window 80,000,000 to 230,000,000 Hz (bounds included). The bypass test uses the unclamped target.
- R3: For a non-bypass request, with T the clamped target, R the reference and g = gcd(T, R), the solver forms N = T/g and M = R/g before any fitting.
- R4: While N > 4095 or M > 511, both N and M are shifted right by one bit together, and the reported values are the first pair that fits.
- R5: After fitting, a zero N or a zero M is reported as 1, so a non-bypass result never has n_div or m_div equal to 0, and bypass = 0.
- R6: A start pulse that arrives while busy is high is ignored, and the running request completes with its own result.
- R7: done is high for exactly one cycle per accepted request. n_div, m_div and bypass change only in the cycle in which done is high, and are held from then until the next done.
- R8: After reset, busy, done, bypass, n_div and m_div are all 0.
- R9: busy is high from the cycle after an accepted non-bypass start until the cycle before done, and busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request pulse; ignored while busy |
| target_hz | input | 32 | Requested output frequency in Hz |
| ref_hz | input | 32 | Reference clock frequency in Hz |
| busy | output | 1 | A solve is in progress |
| done | output | 1 | One-cycle strobe: results valid and updated |
| n_div | output | 12 | Feedback multiplier N (0 in bypass) |
| m_div | output | 9 | Reference divider M (0 in bypass) |
| bypass | output | 1 | PLL bypassed, output equals reference |

## Verification
A bypass answer is due on the first rising edge after the start. A solved answer arrives after a latency that depends on the data and stays under about 150 cycles: GCD iterations, then 33 divider cycles, then one cycle per halving step, then one output cycle. The bench therefore drives start on a falling edge and samples done on every following falling edge, up to a fixed bound. It checks the results on the falling edge where done is first seen, then checks one edge later that done has dropped and the results are unchanged. Expected N, M and bypass come from a Euclid-by-remainder model in the bench, which shares no structure with the binary GCD in the design.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;

   typedef enum logic [2:0] {
      SOLVE_IDLE,
      SOLVE_GCD,
      SOLVE_DIV,
      SOLVE_FIT,
      SOLVE_OUT
   } solve_state_t;

endpackage

// File: rtl/pll_gcd_engine.sv
// Binary (Stein) greatest common divisor, one step per cycle.
module pll_gcd_engine #(
   parameter int W   = 32,
   localparam int K_W = $clog2(W) + 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic         done,
   output logic [W-1:0] g_out
);

   logic [W-1:0]   a_q, b_q, a_org, b_org;
   logic [K_W-1:0] k_q;
   logic           run_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q   <= '0;
         b_q   <= '0;
         a_org <= '0;
         b_org <= '0;
         k_q   <= '0;
         run_q <= 1'b0;
         done  <= 1'b0;
         g_out <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            a_q   <= a_in;
            b_q   <= b_in;
            a_org <= a_in;
            b_org <= b_in;
            k_q   <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (a_q == '0) begin
               g_out <= b_q << k_q;
               done  <= 1'b1;
               run_q <= 1'b0;
            end else if (b_q == '0) begin
               g_out <= a_q << k_q;
               done  <= 1'b1;
               run_q <= 1'b0;
            end else if (!a_q[0] && !b_q[0]) begin
               a_q <= a_q >> 1;
               b_q <= b_q >> 1;
               k_q <= k_q + 1'b1;
            end else if (!a_q[0]) begin
               a_q <= a_q >> 1;
            end else if (!b_q[0]) begin
               b_q <= b_q >> 1;
            end else if (a_q >= b_q) begin
               a_q <= (a_q - b_q) >> 1;
            end else begin
               b_q <= (b_q - a_q) >> 1;
            end
         end
      end
   end

   // R3
   gcd_divides_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (g_out != '0) && ((a_org % g_out) == '0) && ((b_org % g_out) == '0));

endmodule

// File: rtl/pll_serial_div.sv
// Restoring serial divider: one quotient bit per cycle, W cycles.
module pll_serial_div #(
   parameter int W     = 32,
   localparam int CNT_W = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         done,
   output logic [W-1:0] quotient
);

   logic [W-1:0]     rem_q, dsr_q, dvd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic [W:0]       shifted;
   logic             fits;
   logic [W-1:0]     rem_next;

   always_comb begin
      shifted  = {rem_q, quotient[W-1]};
      fits     = shifted[W] || (shifted[W-1:0] >= dsr_q);
      rem_next = shifted[W-1:0] - dsr_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q    <= '0;
         dsr_q    <= '0;
         dvd_q    <= '0;
         cnt_q    <= '0;
         run_q    <= 1'b0;
         done     <= 1'b0;
         quotient <= '0;
      end else begin
         done <= 1'b0;
         if (go) begin
            rem_q    <= '0;
            dsr_q    <= divisor;
            dvd_q    <= dividend;
            quotient <= dividend;
            cnt_q    <= CNT_W'(W);
            run_q    <= 1'b1;
         end else if (run_q) begin
            if (fits) begin
               rem_q    <= rem_next;
               quotient <= {quotient[W-2:0], 1'b1};
            end else begin
               rem_q    <= shifted[W-1:0];
               quotient <= {quotient[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q <= 1'b0;
               done  <= 1'b1;
            end
         end
      end
   end

   // R3
   quotient_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && dsr_q != '0) |->
         ({{W{1'b0}}, quotient} * {{W{1'b0}}, dsr_q} <= {{W{1'b0}}, dvd_q}) &&
         ({{W{1'b0}}, dvd_q} - {{W{1'b0}}, quotient} * {{W{1'b0}}, dsr_q} < {{W{1'b0}}, dsr_q}));

endmodule

// File: rtl/pll_ratio_solver.sv
module pll_ratio_solver
   import pll_ratio_pkg::*;
#(
   parameter int          FREQ_W = 32,
   parameter int          N_W    = 12,
   parameter int          M_W    = 9,
   parameter logic [31:0] F_LOW  = 32'd80_000_000,
   parameter logic [31:0] F_HIGH = 32'd230_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] target_hz,
   input  logic [FREQ_W-1:0] ref_hz,
   output logic              busy,
   output logic              done,
   output logic [N_W-1:0]    n_div,
   output logic [M_W-1:0]    m_div,
   output logic              bypass
);

   localparam logic [FREQ_W-1:0] N_LIM  = FREQ_W'((64'd1 << N_W) - 1);
   localparam logic [FREQ_W-1:0] M_LIM  = FREQ_W'((64'd1 << M_W) - 1);
   localparam logic [FREQ_W-1:0] LO_LIM = FREQ_W'(F_LOW);
   localparam logic [FREQ_W-1:0] HI_LIM = FREQ_W'(F_HIGH);
   localparam int                LANES  = 2;

   initial begin
      if (F_LOW >= F_HIGH || N_W >= FREQ_W || M_W >= FREQ_W || N_W < 1 || M_W < 1)
         $error("pll_ratio_solver: inconsistent parameters");
   end

   solve_state_t      state_q;
   logic [FREQ_W-1:0] tgt_q, ref_q, n_w, m_w, tgt_clamped, gcd_val;
   logic              gcd_go, gcd_done, div_go, accept, is_bypass;
   logic [FREQ_W-1:0] lane_dvd [LANES];
   logic [FREQ_W-1:0] lane_quo [LANES];
   logic              lane_done [LANES];

   always_comb begin
      if (target_hz < LO_LIM)       tgt_clamped = LO_LIM;
      else if (target_hz > HI_LIM)  tgt_clamped = HI_LIM;
      else                          tgt_clamped = target_hz;
      accept    = (state_q == SOLVE_IDLE) && start;
      is_bypass = (target_hz <= ref_hz);
      gcd_go    = accept && !is_bypass;
      div_go    = (state_q == SOLVE_GCD) && gcd_done;
      lane_dvd[0] = tgt_q;
      lane_dvd[1] = ref_q;
   end

   assign busy = (state_q != SOLVE_IDLE);

   pll_gcd_engine #(.W(FREQ_W)) u_gcd (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (gcd_go),
      .a_in  (tgt_clamped),
      .b_in  (ref_hz),
      .done  (gcd_done),
      .g_out (gcd_val)
   );

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      pll_serial_div #(.W(FREQ_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (div_go),
         .dividend (lane_dvd[li]),
         .divisor  (gcd_val),
         .done     (lane_done[li]),
         .quotient (lane_quo[li])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SOLVE_IDLE;
         tgt_q   <= '0;
         ref_q   <= '0;
         n_w     <= '0;
         m_w     <= '0;
         n_div   <= '0;
         m_div   <= '0;
         bypass  <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SOLVE_IDLE: begin
               if (accept) begin
                  if (is_bypass) begin
                     n_div  <= '0;
                     m_div  <= '0;
                     bypass <= 1'b1;
                     done   <= 1'b1;
                  end else begin
                     tgt_q   <= tgt_clamped;
                     ref_q   <= ref_hz;
                     state_q <= SOLVE_GCD;
                  end
               end
            end
            SOLVE_GCD: begin
               if (gcd_done) state_q <= SOLVE_DIV;
            end
            SOLVE_DIV: begin
               if (lane_done[0] && lane_done[1]) begin
                  n_w     <= lane_quo[0];
                  m_w     <= lane_quo[1];
                  state_q <= SOLVE_FIT;
               end
            end
            SOLVE_FIT: begin
               if (n_w > N_LIM || m_w > M_LIM) begin
                  n_w <= n_w >> 1;
                  m_w <= m_w >> 1;
               end else begin
                  state_q <= SOLVE_OUT;
               end
            end
            SOLVE_OUT: begin
               n_div   <= (n_w == '0) ? N_W'(1) : n_w[N_W-1:0];
               m_div   <= (m_w == '0) ? M_W'(1) : m_w[M_W-1:0];
               bypass  <= 1'b0;
               done    <= 1'b1;
               state_q <= SOLVE_IDLE;
            end
            default: state_q <= SOLVE_IDLE;
         endcase
      end
   end

   // R7
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(n_div) && $stable(m_div) && $stable(bypass)));

   // R1
   bypass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bypass) |-> (n_div == '0 && m_div == '0));

   // R5
   nonzero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !bypass) |-> (n_div != '0 && m_div != '0));

   // R9
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> ($stable(tgt_q) && $stable(ref_q)));

endmodule

// File: tb/pll_ratio_solver_bench.sv
module pll_ratio_solver_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] target_hz = '0;
   logic [31:0] ref_hz = '0;
   logic        busy, done, bypass;
   logic [11:0] n_div;
   logic [8:0]  m_div;

   int vectors = 0;
   int errors  = 0;

   always #4 clk = ~clk;

   pll_ratio_solver u_pll_ratio_solver (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .target_hz (target_hz),
      .ref_hz    (ref_hz),
      .busy      (busy),
      .done      (done),
      .n_div     (n_div),
      .m_div     (m_div),
      .bypass    (bypass)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Independent model: Euclid by remainder, then fitting and zero fix.
   task automatic model(input logic [31:0] t, input logic [31:0] r,
                        output logic [11:0] n, output logic [8:0] m, output logic byp);
      logic [31:0] tc, a, b, tmp, nn, mm;
      if (t <= r) begin
         n = '0; m = '0; byp = 1'b1;
      end else begin
         tc = (t < 32'd80_000_000) ? 32'd80_000_000 :
              (t > 32'd230_000_000) ? 32'd230_000_000 : t;
         a = tc; b = r;
         while (b != 0) begin
            tmp = a % b; a = b; b = tmp;
         end
         nn = tc / a; mm = r / a;
         while (nn > 4095 || mm > 511) begin
            nn = nn >> 1; mm = mm >> 1;
         end
         if (nn == 0) nn = 1;
         if (mm == 0) mm = 1;
         n = nn[11:0]; m = mm[8:0]; byp = 1'b0;
      end
   endtask

   // Drives one start pulse, optionally a second one while busy, waits for done.
   task automatic run_req(input logic [31:0] t, input logic [31:0] r, input string req,
                          input bit poke, input logic [31:0] t2, input logic [31:0] r2);
      logic [11:0] en; logic [8:0] em; logic eb;
      int cyc = 0;
      bit seen_busy = 0;
      model(t, r, en, em, eb);
      @(negedge clk);
      start = 1'b1; target_hz = t; ref_hz = r;
      do begin
         @(negedge clk);
         if (cyc == 0) start = 1'b0;
         if (busy) seen_busy = 1;
         if (poke && cyc == 3) begin
            start = 1'b1; target_hz = t2; ref_hz = r2;
         end else if (poke && cyc == 4) begin
            start = 1'b0;
         end
         cyc++;
      end while (!done && cyc < 400);
      start = 1'b0;
      chk(req, "done seen", 32'(done), 32'd1);
      chk(req, "n_div", 32'(n_div), 32'(en));
      chk(req, "m_div", 32'(m_div), 32'(em));
      chk(req, "bypass", 32'(bypass), 32'(eb));
      chk("R9", "busy with done", 32'(busy), 32'd0);
      if (eb) begin
         chk("R1", "bypass latency", 32'(cyc), 32'd1);
         chk("R1", "busy during bypass", 32'(seen_busy), 32'd0);
      end else begin
         chk("R9", "busy during solve", 32'(seen_busy), 32'd1);
      end
      @(negedge clk);
      chk("R7", "done single cycle", 32'(done), 32'd0);
      repeat (3) @(negedge clk);
      chk("R7", "n_div held", 32'(n_div), 32'(en));
      chk("R7", "m_div held", 32'(m_div), 32'(em));
      chk("R7", "bypass held", 32'(bypass), 32'(eb));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "busy", 32'(busy), 0);
      chk("R8", "done", 32'(done), 0);
      chk("R8", "bypass", 32'(bypass), 0);
      chk("R8", "n_div", 32'(n_div), 0);
      chk("R8", "m_div", 32'(m_div), 0);
   endtask

   task automatic t_bypass();
      run_req(32'd10_000_000, 32'd25_000_000, "R1", 0, 0, 0);
      run_req(32'd27_000_000, 32'd27_000_000, "R1", 0, 0, 0);
   endtask

   task automatic t_exact();
      run_req(32'd100_000_000, 32'd25_000_000, "R3", 0, 0, 0);
      chk("R3", "n_div 100M/25M", 32'(n_div), 32'd4);
      chk("R3", "m_div 100M/25M", 32'(m_div), 32'd1);
   endtask

   task automatic t_clamp();
      run_req(32'd50_000_000, 32'd27_000_000, "R2", 0, 0, 0);
      chk("R2", "low clamp n", 32'(n_div), 32'd80);
      chk("R2", "low clamp m", 32'(m_div), 32'd27);
      run_req(32'd300_000_000, 32'd27_000_000, "R2", 0, 0, 0);
      chk("R2", "high clamp n", 32'(n_div), 32'd230);
      run_req(32'd240_000_000, 32'd235_000_000, "R2", 0, 0, 0);
      chk("R2", "clamp below ref n", 32'(n_div), 32'd46);
      chk("R2", "clamp below ref m", 32'(m_div), 32'd47);
   endtask

   task automatic t_fit();
      run_req(32'd100_000_007, 32'd27_000_000, "R4", 0, 0, 0);
      run_req(32'd123_456_789, 32'd19_200_000, "R4", 0, 0, 0);
   endtask

   task automatic t_zero_fix();
      run_req(32'd230_000_000, 32'd1, "R5", 0, 0, 0);
      chk("R5", "m forced to 1", 32'(m_div), 32'd1);
      run_req(32'd90_000_000, 32'd0, "R5", 0, 0, 0);
      chk("R5", "ref zero n", 32'(n_div), 32'd1);
      chk("R5", "ref zero m", 32'(m_div), 32'd1);
   endtask

   task automatic t_ignore();
      run_req(32'd100_000_000, 32'd25_000_000, "R6", 1, 32'd300_000_000, 32'd1);
      chk("R6", "first request kept n", 32'(n_div), 32'd4);
      @(negedge clk);
      chk("R6", "no extra done", 32'(done), 32'd0);
   endtask

   initial begin
      t_reset();
      t_bypass();
      t_exact();
      t_clamp();
      t_fit();
      t_zero_fix();
      t_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule